// File: doc/BRIEF.md
# SM3 message expansion step unit

This block performs the second partial step of SM3 message-word expansion on three 128-bit vector operands. It takes a 32-bit instruction word and checks it against one fixed opcode pattern. It pulls out three 5-bit register indices and drives them to an external register file as read addresses. The same cycle, it captures the three 128-bit operands that come back. The first operand (D) is both a source and the write-back target.

In the datapath, every 32-bit lane of M is rotated left by 7. The result is XORed with N to form T, and D XOR T is the preliminary result. The lowest lane of T then goes through a rotate-and-XOR mixing function, and only the top lane of the result takes that mixing term. All rotations are fixed wiring. The unit is a two-stage pipeline with a valid/ready handshake on both sides. Its latency is the same for every operand value.

If an instruction word has the wrong encoding, or the feature-enable input is low when the word is accepted, the unit still returns a result slot. In that slot the undefined flag is raised and the write-enable stays low.

Top module: `sm3_msgexp_step`

## Requirements
- R1: An accepted word is defined only when bits 31:21 equal 11001110011 and bits 15:10 equal 110001. Any other word gives an output slot with `undef_o`=1 and `wb_en_o`=0.
- R2: If `feat_en_i` is 0 when a word is accepted, that word gives `undef_o`=1 and `wb_en_o`=0, even when its encoding is valid.
- R3: The read indices come combinationally from `instr_i`: D from bits 4:0, N from bits 9:5, M from bits 20:16. `wb_idx_o` carries the D index of the instruction in the output slot.
- R4: For a defined word, each of result lanes 0..2 (bits 95:0) equals D ^ N ^ rol7(M) for that lane.
- R5: For a defined word, result lane 3 (bits 127:96) equals D ^ T ^ W'. Here T = N ^ rol7-per-lane(M), W = rol15(T[31:0]) and W' = W ^ rol15(W) ^ rol23(W).
- R6: Take a word accepted on a clock edge while `out_ready_i` stays high. Its output slot is valid right after the second edge, whatever the data. Back-to-back words are accepted one per cycle.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, the output slot holds with stable contents. `in_ready_o` falls only when both stages are full and the output is stalled. No accepted word is lost or reordered.
- R8: Reset clears both stage valid flags: `out_valid_o`=0, `wb_en_o`=0, `undef_o`=0, `in_ready_o`=1.
- R9: `wb_en_o` and `undef_o` are never high together, and each is high only with `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feat_en_i | input | 1 | Feature enable, sampled on acceptance |
| in_valid_i | input | 1 | Instruction word valid |
| in_ready_o | output | 1 | Unit can accept a word |
| instr_i | input | 32 | Instruction word |
| rd_idx_d_o | output | 5 | Read index, D operand |
| rd_idx_n_o | output | 5 | Read index, N operand |
| rd_idx_m_o | output | 5 | Read index, M operand |
| rd_data_d_i | input | 128 | D operand read data |
| rd_data_n_i | input | 128 | N operand read data |
| rd_data_m_i | input | 128 | M operand read data |
| out_valid_o | output | 1 | Output slot valid |
| out_ready_i | input | 1 | Downstream accepts the slot |
| wb_en_o | output | 1 | Write-back enable (defined word) |
| undef_o | output | 1 | Undefined-instruction flag |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | 128 | Result data |

## Verification
The assertions check four things on every cycle:
- the write-enable and the undefined flag never overlap, and neither appears without a valid slot;
- a stalled slot holds steady;
- input back-pressure appears only when both stages are full behind a stalled output;
- an accepted word reaches the output two edges later when the downstream is ready.

Only the bench's scenarios can show that the result values are right. It runs the lower-lane and top-lane arithmetic against an independent model, including rotation wrap-around, all-zero and all-one operands, and aliased N/M indices. The bench also shows that each kind of encoding error and the disabled feature are classified correctly. Finally, it confirms that words survive a stall in order.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;

  // fixed opcode fields
  localparam int OPC_HI_LSB  = 21;
  localparam int OPC_HI_W    = 11;
  localparam logic [OPC_HI_W-1:0] OPC_HI = 11'b110_0111_0011;
  localparam int OPC_MID_LSB = 10;
  localparam int OPC_MID_W   = 6;
  localparam logic [OPC_MID_W-1:0] OPC_MID = 6'b11_0001;

  // operand index fields
  localparam int IDX_D_LSB = 0;
  localparam int IDX_N_LSB = 5;
  localparam int IDX_M_LSB = 16;

  // rotation amounts
  localparam int ROT_M   = 7;
  localparam int ROT_PRE = 15;
  localparam int ROT_A   = 15;
  localparam int ROT_B   = 23;

  typedef struct packed {
    logic             undef;
    logic [IDX_W-1:0] idx_d;
  } slot_ctl_t;
endpackage

// File: rtl/sm3x_rol.sv
module sm3x_rol #(
  parameter int W = 32,
  parameter int R = 7
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  localparam int RM = R % W;
  generate
    if (RM == 0) begin : g_none
      assign y_o = a_i;
    end else begin : g_rot
      assign y_o = {a_i[W-RM-1:0], a_i[W-1:W-RM]};
    end
  endgenerate
endmodule

// File: rtl/sm3x_decode.sv
module sm3x_decode
  import sm3x_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               feat_en_i,
  output logic [IDX_W-1:0]   idx_d_o,
  output logic [IDX_W-1:0]   idx_n_o,
  output logic [IDX_W-1:0]   idx_m_o,
  output logic               undef_o
);
  logic hi_ok, mid_ok;

  assign hi_ok  = instr_i[OPC_HI_LSB  +: OPC_HI_W]  == OPC_HI;
  assign mid_ok = instr_i[OPC_MID_LSB +: OPC_MID_W] == OPC_MID;

  assign idx_d_o = instr_i[IDX_D_LSB +: IDX_W];
  assign idx_n_o = instr_i[IDX_N_LSB +: IDX_W];
  assign idx_m_o = instr_i[IDX_M_LSB +: IDX_W];

  assign undef_o = !(hi_ok && mid_ok && feat_en_i);
endmodule

// File: rtl/sm3x_lane_rot.sv
module sm3x_lane_rot #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32,
  parameter int ROT    = 7
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int N_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    sm3x_rol #(.W(LANE_W), .R(ROT)) u_rol (
      .a_i (a_i[l*LANE_W +: LANE_W]),
      .y_o (y_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/sm3x_top_mix.sv
module sm3x_top_mix #(
  parameter int LANE_W  = 32,
  parameter int ROT_PRE = 15,
  parameter int ROT_A   = 15,
  parameter int ROT_B   = 23
) (
  input  logic [LANE_W-1:0] t_lo_i,
  output logic [LANE_W-1:0] mix_o
);
  logic [LANE_W-1:0] w, w_a, w_b;

  sm3x_rol #(.W(LANE_W), .R(ROT_PRE)) u_pre (.a_i(t_lo_i), .y_o(w));
  sm3x_rol #(.W(LANE_W), .R(ROT_A))   u_ra  (.a_i(w),      .y_o(w_a));
  sm3x_rol #(.W(LANE_W), .R(ROT_B))   u_rb  (.a_i(w),      .y_o(w_b));

  assign mix_o = w ^ w_a ^ w_b;
endmodule

// File: rtl/sm3x_core.sv
module sm3x_core
  import sm3x_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic [DATA_W-1:0] n_i,
  input  logic [DATA_W-1:0] m_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int TOP_LSB = DATA_W - LANE_W;

  logic [DATA_W-1:0] m_rot, t, pre;
  logic [LANE_W-1:0] mix;

  sm3x_lane_rot #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ROT(ROT_M)) u_lrot (
    .a_i (m_i),
    .y_o (m_rot)
  );

  assign t   = n_i ^ m_rot;
  assign pre = d_i ^ t;

  sm3x_top_mix #(
    .LANE_W (LANE_W),
    .ROT_PRE(ROT_PRE),
    .ROT_A  (ROT_A),
    .ROT_B  (ROT_B)
  ) u_mix (
    .t_lo_i (t[LANE_W-1:0]),
    .mix_o  (mix)
  );

  // only the top lane takes the mixing term
  assign res_o = {pre[DATA_W-1:TOP_LSB] ^ mix, pre[TOP_LSB-1:0]};
endmodule

// File: rtl/sm3_msgexp_step.sv
module sm3_msgexp_step
  import sm3x_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               feat_en_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [IDX_W-1:0]   rd_idx_d_o,
  output logic [IDX_W-1:0]   rd_idx_n_o,
  output logic [IDX_W-1:0]   rd_idx_m_o,
  input  logic [DATA_W-1:0]  rd_data_d_i,
  input  logic [DATA_W-1:0]  rd_data_n_i,
  input  logic [DATA_W-1:0]  rd_data_m_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               wb_en_o,
  output logic               undef_o,
  output logic [IDX_W-1:0]   wb_idx_o,
  output logic [DATA_W-1:0]  wb_data_o
);
  logic              dec_undef;
  logic              s1_valid_q, s2_valid_q;
  slot_ctl_t         s1_ctl_q, s2_ctl_q;
  logic [DATA_W-1:0] s1_d_q, s1_n_q, s1_m_q;
  logic [DATA_W-1:0] s2_data_q, core_res;
  logic              s1_adv, s2_adv, accept;

  sm3x_decode u_dec (
    .instr_i   (instr_i),
    .feat_en_i (feat_en_i),
    .idx_d_o   (rd_idx_d_o),
    .idx_n_o   (rd_idx_n_o),
    .idx_m_o   (rd_idx_m_o),
    .undef_o   (dec_undef)
  );

  assign s2_adv     = !s2_valid_q || out_ready_i;
  assign s1_adv     = !s1_valid_q || s2_adv;
  assign in_ready_o = s1_adv;
  assign accept     = in_valid_i && s1_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else begin
      if (s1_adv) s1_valid_q <= in_valid_i;
      if (s2_adv) s2_valid_q <= s1_valid_q;
    end
  end

  // stage one: decode result and operand capture
  always_ff @(posedge clk_i) begin
    if (accept) begin
      s1_ctl_q.undef <= dec_undef;
      s1_ctl_q.idx_d <= rd_idx_d_o;
      s1_d_q         <= rd_data_d_i;
      s1_n_q         <= rd_data_n_i;
      s1_m_q         <= rd_data_m_i;
    end
  end

  sm3x_core #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_core (
    .d_i   (s1_d_q),
    .n_i   (s1_n_q),
    .m_i   (s1_m_q),
    .res_o (core_res)
  );

  // stage two: registered result
  always_ff @(posedge clk_i) begin
    if (s2_adv && s1_valid_q) begin
      s2_ctl_q  <= s1_ctl_q;
      s2_data_q <= core_res;
    end
  end

  assign out_valid_o = s2_valid_q;
  assign wb_en_o     = s2_valid_q && !s2_ctl_q.undef;
  assign undef_o     = s2_valid_q && s2_ctl_q.undef;
  assign wb_idx_o    = s2_ctl_q.idx_d;
  assign wb_data_o   = s2_data_q;
endmodule

// File: rtl/sm3x_chk.sv
module sm3x_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              wb_en_o,
  input logic              undef_o,
  input logic [4:0]        wb_idx_o,
  input logic [DATA_W-1:0] wb_data_o
);
  // R9
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_en_o && undef_o));

  // R9
  flag_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || undef_o) |-> out_valid_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(wb_data_o) && $stable(wb_idx_o) && $stable(undef_o)));

  // R7
  backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (out_valid_o && !out_ready_i));

  // R6
  fixed_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_i && $past(in_valid_i && in_ready_o)) |=> out_valid_o);

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!out_valid_o && in_ready_o);
    end
  end
endmodule

bind sm3_msgexp_step sm3x_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .wb_en_o     (wb_en_o),
  .undef_o     (undef_o),
  .wb_idx_o    (wb_idx_o),
  .wb_data_o   (wb_data_o)
);

// File: tb/sm3_msgexp_step_tb.sv
`timescale 1ns/1ps
module sm3_msgexp_step_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         feat_en_i = 1'b1;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [31:0]  instr_i = '0;
  logic [4:0]   rd_idx_d_o, rd_idx_n_o, rd_idx_m_o;
  logic [127:0] rd_data_d_i, rd_data_n_i, rd_data_m_i;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic         wb_en_o, undef_o;
  logic [4:0]   wb_idx_o;
  logic [127:0] wb_data_o;

  logic [127:0] regs [32];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rd_data_d_i = regs[rd_idx_d_o];
  assign rd_data_n_i = regs[rd_idx_n_o];
  assign rd_data_m_i = regs[rd_idx_m_o];

  sm3_msgexp_step u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .feat_en_i(feat_en_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .instr_i(instr_i),
    .rd_idx_d_o(rd_idx_d_o), .rd_idx_n_o(rd_idx_n_o), .rd_idx_m_o(rd_idx_m_o),
    .rd_data_d_i(rd_data_d_i), .rd_data_n_i(rd_data_n_i), .rd_data_m_i(rd_data_m_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .wb_en_o(wb_en_o),
    .undef_o(undef_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [31:0] enc(input logic [4:0] m, n, d);
    return {11'b110_0111_0011, m, 6'b11_0001, n, d};
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] d, n, m);
    logic [127:0] t;
    logic [31:0]  w, w2;
    for (int l = 0; l < 4; l++) t[l*32 +: 32] = n[l*32 +: 32] ^ rl(m[l*32 +: 32], 7);
    w  = rl(t[31:0], 15);
    w2 = w ^ rl(w, 15) ^ rl(w, 23);
    model = d ^ t;
    model[127:96] = model[127:96] ^ w2;
  endfunction

  typedef struct packed {
    logic [31:0] instr;
    logic        feat;
    logic        exp_undef;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{enc(5'd1,  5'd2,  5'd3),  1'b1, 1'b0},
    '{enc(5'd0,  5'd0,  5'd0),  1'b1, 1'b0},  // all-zero operands
    '{enc(5'd31, 5'd31, 5'd31), 1'b1, 1'b0},  // all-one operands
    '{enc(5'd5,  5'd6,  5'd7),  1'b0, 1'b1},  // R2 feature off
    '{enc(5'd1,  5'd2,  5'd3) ^ 32'h0020_0000, 1'b1, 1'b1},  // R1 bit 21 flipped
    '{enc(5'd1,  5'd2,  5'd3) ^ 32'h0000_1000, 1'b1, 1'b1},  // R1 bit 12 flipped
    '{enc(5'd30, 5'd29, 5'd1),  1'b1, 1'b0},  // wrap-around bits in M
    '{enc(5'd8,  5'd8,  5'd9),  1'b1, 1'b0}   // N and M alias
  };

  typedef struct {
    logic         undef;
    logic         feat_off;
    logic [4:0]   idx;
    logic [127:0] data;
  } exp_t;
  exp_t exp_q[$];
  logic mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [31:0] ins, input logic feat, input logic undef);
    exp_t e;
    e.undef    = undef;
    e.feat_off = !feat;
    e.idx      = ins[4:0];
    e.data     = model(regs[ins[4:0]], regs[ins[9:5]], regs[ins[20:16]]);
    exp_q.push_back(e);
  endtask

  // drive at negedge, return just after the accepting posedge
  task automatic send(input logic [31:0] ins, input logic feat, input logic undef);
    @(negedge clk);
    instr_i = ins; feat_en_i = feat; in_valid_i = 1'b1;
    #1;
    while (!in_ready_o) begin
      @(negedge clk); #1;
    end
    push_exp(ins, feat, undef);
    @(posedge clk);
  endtask

  always @(negedge clk) begin
    #2;
    if (mon_en && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected slot", 128'(out_valid_o), 128'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.undef) begin
          chk(undef_o && !wb_en_o, e.feat_off ? "R2 undef" : "R1 undef",
              {wb_en_o, undef_o}, 128'b01);
        end else begin
          chk(wb_en_o && !undef_o, "R9 defined flags", {wb_en_o, undef_o}, 128'b10);
          chk(wb_idx_o == e.idx, "R3 wb index", 128'(wb_idx_o), 128'(e.idx));
          chk(wb_data_o[95:0] == e.data[95:0], "R4 lower lanes",
              128'(wb_data_o[95:0]), 128'(e.data[95:0]));
          chk(wb_data_o[127:96] == e.data[127:96], "R5 top lane",
              128'(wb_data_o[127:96]), 128'(e.data[127:96]));
        end
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  initial begin
    int c0;
    logic [127:0] held;
    for (int i = 0; i < 32; i++)
      for (int k = 0; k < 4; k++)
        regs[i][k*32 +: 32] = 32'h9e37_79b9 * (i * 4 + k + 1) ^ 32'h5a5a_0f0f;
    regs[0]  = '0;
    regs[31] = '1;
    regs[30] = {4{32'h8000_0001}};

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R8 reset state
    chk(!out_valid_o, "R8 out_valid", 128'(out_valid_o), 0);
    chk(in_ready_o, "R8 in_ready", 128'(in_ready_o), 1);
    chk(!wb_en_o && !undef_o, "R8 flags", {wb_en_o, undef_o}, 0);
    rst_ni = 1'b1;

    // R3 read indices are combinational
    @(negedge clk);
    instr_i = enc(5'd7, 5'd12, 5'd25);
    #1;
    chk(rd_idx_d_o == 5'd25, "R3 D index", 128'(rd_idx_d_o), 25);
    chk(rd_idx_n_o == 5'd12, "R3 N index", 128'(rd_idx_n_o), 12);
    chk(rd_idx_m_o == 5'd7,  "R3 M index", 128'(rd_idx_m_o), 7);
    mon_en = 1'b1;

    // R6 fixed latency
    send(enc(5'd4, 5'd10, 5'd17), 1'b1, 1'b0);
    @(negedge clk); in_valid_i = 1'b0; #1;
    chk(!out_valid_o, "R6 not yet valid", 128'(out_valid_o), 0);
    @(negedge clk); #1;
    chk(out_valid_o, "R6 valid after two edges", 128'(out_valid_o), 1);
    repeat (2) @(negedge clk);

    // vector table, back to back (R6 throughput)
    c0 = cyc;
    for (int i = 0; i < NV; i++) send(VECS[i].instr, VECS[i].feat, VECS[i].exp_undef);
    chk(cyc - c0 == NV, "R6 one per cycle", 128'(cyc - c0), 128'(NV));
    @(negedge clk); in_valid_i = 1'b0;
    repeat (4) @(negedge clk);

    // R7 stall
    out_ready_i = 1'b0;
    send(enc(5'd11, 5'd12, 5'd13), 1'b1, 1'b0);
    send(enc(5'd14, 5'd15, 5'd16), 1'b1, 1'b0);
    @(negedge clk);
    instr_i = enc(5'd17, 5'd18, 5'd19); in_valid_i = 1'b1;
    #1;
    chk(!in_ready_o, "R7 backpressure", 128'(in_ready_o), 0);
    held = wb_data_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(out_valid_o && wb_data_o == held, "R7 slot held", wb_data_o, held);
    end
    @(negedge clk);
    out_ready_i = 1'b1;
    #1;
    chk(in_ready_o, "R7 ready after release", 128'(in_ready_o), 1);
    push_exp(instr_i, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); in_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 no loss", 128'(exp_q.size()), 0);
    finish_run();
  end
endmodule